// File: doc/BRIEF.md
# NMI Acceptance Gate

This block sits in a processor core and decides in which cycle a raised non-maskable interrupt request is taken. A bounded down-counter stands in for the usual "handler active" flag. Taking an NMI loads the counter with a fixed hold value, which is chosen to be longer than the worst-case handler in cycles. The counter then counts toward zero without help and stays there. While the counter is nonzero, further requests are ignored. A return-from-interrupt strobe from the decoder empties the counter at once.

Because the mask clears itself, an upset counter can never block NMIs for good. Whatever value the register holds, a request held on the pin is taken within 2^CNT_W cycles. When a take happens, the core's fetch logic sees a one-cycle strobe together with a handler address that is fixed at build time. The strobe is qualified by an instruction-boundary signal, so a take only ever starts at a clean point between instructions.

Top module: `nmi_accept_gate`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the counter holds INIT_CNT. nmi_busy equals (INIT_CNT != 0), and nmi_take is low whenever nmi_pin is low.
- R2: nmi_take is high in the same cycle (combinational) exactly when nmi_pin is high, insn_boundary is high and the counter reads zero.
- R3: A take loads the counter with HOLD_MAX on the next edge. With the pin held, the next take comes exactly HOLD_MAX+1 cycles after the previous one, so nmi_take is never high for two consecutive cycles.
- R4: A nonzero counter drops by one each cycle. A zero counter stays at zero. nmi_busy is high exactly when the counter is nonzero.
- R5: A request (held or pulsed) while nmi_busy is high produces no take and leaves the countdown timing unchanged.
- R6: iret_exec in a cycle without a take clears the counter on the next edge, so a held request is taken in the following cycle.
- R7: When iret_exec and a take fall in the same cycle, the take wins and the counter loads HOLD_MAX.
- R8: With insn_boundary low there is no take, and the counter keeps counting down and then holds at zero. The first cycle with insn_boundary high and the pin high then produces the take.
- R9: From any start value, including values above HOLD_MAX, a request held with insn_boundary high is first taken in the cycle whose index equals the start value, so within 2^CNT_W cycles.
- R10: vector_addr always equals the build-time parameter HANDLER_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Level of the non-maskable interrupt request |
| iret_exec | input | 1 | Strobe: a return-from-interrupt is executing |
| insn_boundary | input | 1 | High when the core sits between instructions |
| nmi_take | output | 1 | One-cycle strobe: vector to the handler now |
| nmi_busy | output | 1 | High while the mask counter is nonzero |
| vector_addr | output | ADDR_W | Hardwired handler address |

## Verification
A wrong counter value can only show up at the ports in two ways: a shift in the cycle where nmi_take fires, or a change in when nmi_busy drops. If the counter holds a wrong value while a request is pending, the take moves by exactly that error, and this is visible within at most 2^CNT_W cycles. The bench therefore starts copies of the block from every possible counter value. For each copy it predicts, with plain arithmetic, the cycle index of every take and every busy level. It also walks a single copy through the orderings of iret, boundary and take that decide whether the gate reopens early, on time, or late.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;

  // What the mask counter does on the next edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_DEC   = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;

  // Priority: a take reloads, then an iret clears, then the counter counts down
  function automatic cnt_act_e pick_action(input logic take,
                                           input logic iret,
                                           input logic nonzero);
    if (take)         return ACT_LOAD;
    else if (iret)    return ACT_CLEAR;
    else if (nonzero) return ACT_DEC;
    else              return ACT_HOLD;
  endfunction

endpackage

// File: rtl/nmi_accept_decide.sv
module nmi_accept_decide
  import nmi_gate_pkg::*;
(
  input  logic     nmi_pin,
  input  logic     insn_boundary,
  input  logic     iret_exec,
  input  logic     cnt_zero,
  output logic     take,
  output cnt_act_e act
);

  function automatic logic accept_now(input logic pin, input logic bnd,
                                      input logic zero);
    return pin & bnd & zero;
  endfunction

  assign take = accept_now(nmi_pin, insn_boundary, cnt_zero);
  assign act  = pick_action(take, iret_exec, ~cnt_zero);

endmodule

// File: rtl/nmi_mask_counter.sv
module nmi_mask_counter
  import nmi_gate_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HOLD_MAX = 200,
  parameter int INIT_CNT = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cnt_act_e act,
  output logic     cnt_zero
);

  localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(HOLD_MAX);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_CNT);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] step(input cnt_act_e a,
                                            input logic [CNT_W-1:0] c);
    case (a)
      ACT_LOAD:  return MAX_V;
      ACT_CLEAR: return '0;
      ACT_DEC:   return c - 1'b1;
      default:   return c;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= INIT_V;
    else        cnt <= step(act, cnt);
  end

  assign cnt_zero = (cnt == '0);

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DEC) |=> (cnt + 1'b1) == $past(cnt));

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && act == ACT_HOLD) |=> cnt_zero);

  // R3
  load_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) |=> cnt == MAX_V);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLEAR) |=> cnt_zero);

endmodule

// File: rtl/nmi_vector_source.sv
module nmi_vector_source #(
  parameter int              ADDR_W       = 32,
  parameter longint unsigned HANDLER_ADDR = 64'h8
) (
  output logic [ADDR_W-1:0] vec
);

  assign vec = ADDR_W'(HANDLER_ADDR);

endmodule

// File: rtl/nmi_accept_gate.sv
module nmi_accept_gate
  import nmi_gate_pkg::*;
#(
  parameter int              CNT_W        = 8,
  parameter int              HOLD_MAX     = 200,
  parameter int              INIT_CNT     = 0,
  parameter int              ADDR_W       = 32,
  parameter longint unsigned HANDLER_ADDR = 64'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic              iret_exec,
  input  logic              insn_boundary,
  output logic              nmi_take,
  output logic              nmi_busy,
  output logic [ADDR_W-1:0] vector_addr
);

  localparam logic [CNT_W:0] WAIT_LIMIT = (CNT_W+1)'((1 << CNT_W) - 1);

  cnt_act_e act;
  logic     cnt_zero;
  logic     take;

  nmi_accept_decide u_decide (
    .nmi_pin       (nmi_pin),
    .insn_boundary (insn_boundary),
    .iret_exec     (iret_exec),
    .cnt_zero      (cnt_zero),
    .take          (take),
    .act           (act)
  );

  nmi_mask_counter #(
    .CNT_W    (CNT_W),
    .HOLD_MAX (HOLD_MAX),
    .INIT_CNT (INIT_CNT)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .cnt_zero (cnt_zero)
  );

  nmi_vector_source #(
    .ADDR_W       (ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_vector (
    .vec (vector_addr)
  );

  assign nmi_take = take;
  assign nmi_busy = ~cnt_zero;

  // Run length of a pending, boundary-qualified request that is not yet taken
  logic [CNT_W:0] stall_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stall_run <= '0;
    else if (nmi_pin && insn_boundary && !nmi_take)
      stall_run <= (stall_run == '1) ? stall_run : stall_run + 1'b1;
    else
      stall_run <= '0;
  end

  // R2
  take_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> (nmi_pin && insn_boundary && !nmi_busy));

  // R3
  take_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> (!nmi_take && nmi_busy));

  // R6
  iret_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iret_exec && !nmi_take) |=> !nmi_busy);

  // R9
  take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run <= WAIT_LIMIT);

endmodule

// File: tb/nmi_accept_gate_tb.sv
`timescale 1ns/1ps
module nmi_accept_gate_tb;

  localparam int W     = 4;
  localparam int MAXV  = 9;
  localparam int NINST = 1 << W;
  localparam int PER   = MAXV + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, iret = 1'b0, bnd = 1'b0;
  logic take, busy;
  logic [15:0] vaddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nmi_accept_gate #(.CNT_W(W), .HOLD_MAX(MAXV), .INIT_CNT(0),
                    .ADDR_W(16), .HANDLER_ADDR(64'hFFF0)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(pin), .iret_exec(iret),
    .insn_boundary(bnd), .nmi_take(take), .nmi_busy(busy),
    .vector_addr(vaddr));

  // Sweep copies: one per start value, request held on a boundary
  logic [NINST-1:0] sw_take, sw_busy;
  logic [7:0] sw_vec [NINST];
  for (genvar g = 0; g < NINST; g++) begin : g_sweep
    nmi_accept_gate #(.CNT_W(W), .HOLD_MAX(MAXV), .INIT_CNT(g),
                      .ADDR_W(8), .HANDLER_ADDR(64'h40)) u_sw (
      .clk(clk), .rst_n(rst_n), .nmi_pin(1'b1), .iret_exec(1'b0),
      .insn_boundary(1'b1), .nmi_take(sw_take[g]), .nmi_busy(sw_busy[g]),
      .vector_addr(sw_vec[g]));
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic p, input logic b, input logic r,
                     input logic et, input logic eb, input string tag);
    pin = p; bnd = b; iret = r;
    @(negedge clk);
    chk(take, et, {tag, " take"});
    chk(busy, eb, {tag, " busy"});
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(take, 1'b0, "R1 take in reset");
    chk(busy, 1'b0, "R1 busy in reset");
    for (int i = 0; i < NINST; i++)
      chk(sw_busy[i], (i != 0), $sformatf("R1 sweep busy in reset v=%0d", i));
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    cyc(0, 1, 0, 0, 0, "R1 idle after reset");
    n_cmp++;
    if (vaddr !== 16'hFFF0) begin
      n_bad++;
      $display("FAIL R10: got %h expected fff0", vaddr);
    end
    cyc(1, 1, 0, 1, 0, "R2 take when idle");
    for (int k = 1; k < PER; k++) cyc(1, 1, 0, 0, 1, "R5 held pin masked");
    cyc(1, 1, 0, 1, 0, "R3 retake after MAX+1");
    // R6: iret mid-handler reopens the gate
    cyc(1, 1, 0, 0, 1, "R6 before iret");
    cyc(1, 1, 0, 0, 1, "R6 before iret");
    cyc(1, 1, 1, 0, 1, "R6 iret cycle");
    cyc(1, 1, 0, 1, 0, "R6 take after iret");
    // R4: plain countdown with pin low
    for (int k = 1; k < PER; k++) cyc(0, 1, 0, 0, 1, "R4 counting down");
    cyc(0, 1, 0, 0, 0, "R4 reached zero");
    cyc(0, 1, 0, 0, 0, "R4 holds zero");
    cyc(0, 1, 1, 0, 0, "R6 iret while idle");
    // R7: iret with take, take wins
    cyc(1, 1, 1, 1, 0, "R7 take with iret");
    for (int k = 1; k < PER; k++) cyc(1, 1, 0, 0, 1, "R7 load wins over clear");
    cyc(1, 1, 0, 1, 0, "R7 retake");
    // R8: boundary low suppresses take
    for (int k = 1; k < PER; k++) cyc(1, 0, 0, 0, 1, "R8 counting off boundary");
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, "R8 no take off boundary");
    cyc(1, 1, 0, 1, 0, "R8 take at boundary");
    // R5: pulse during busy is ignored and does not disturb timing
    cyc(0, 1, 0, 0, 1, "R5 busy");
    cyc(1, 1, 0, 0, 1, "R5 pulse ignored");
    for (int k = 3; k < PER; k++) cyc(0, 1, 0, 0, 1, "R5 still counting");
    cyc(0, 1, 0, 0, 0, "R5 count unaffected");
    cyc(1, 1, 0, 1, 0, "R5 taken after expiry");
    n_cmp++;
    if (vaddr !== 16'hFFF0) begin
      n_bad++;
      $display("FAIL R10: got %h expected fff0", vaddr);
    end

    // R9 sweep over every start value
    pin = 0; bnd = 0; iret = 0;
    do_reset();
    for (int c = 0; c < 4 * PER; c++) begin
      @(negedge clk);
      for (int v = 0; v < NINST; v++) begin
        logic et, eb;
        if (c < v) begin
          et = 1'b0; eb = 1'b1;
        end else begin
          et = (((c - v) % PER) == 0);
          eb = !et;
        end
        chk(sw_take[v], et, $sformatf("R9 take v=%0d c=%0d", v, c));
        chk(sw_busy[v], eb, $sformatf("R9 busy v=%0d c=%0d", v, c));
      end
      @(posedge clk); #1;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule